// File: doc/BRIEF.md
# Double-Buffered PWM Channel with Edge and Center Alignment

This block is one 8-bit pulse-width channel. Software programs a period and a duty value through write strobes that share one data bus. Each value lands first in a staging buffer and is read back from there. The counter compares against a separate active copy. The active copy is refreshed only when a period completes, when the counter is restarted, or while the channel is off. Because of this, every output period is built wholly from one consistent pair of settings.

The counter moves only on cycles where the prescaled channel clock enable is high. In edge mode it counts upward and wraps, so the output period is the period value in channel ticks. In center mode it climbs to the top and then descends, giving twice that length with the pulse centred in the period. A polarity input selects the active level. When the channel is switched off, the output rests at the inactive level.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: After reset both readback ports are 0 and, with the channel off, `pwm_out` equals `~pol`.
- R2: A period or duty write while `ch_en` is 1 changes only the staged value. The running period finishes with the old active values, and the new values apply from the next period start.
- R3: A period or duty write while `ch_en` is 0 updates the staged and the active value on the same clock edge.
- R4: While `ch_en` is 0, the active values are reloaded from the staged values, so settings staged while running take effect after the channel is turned off and on again.
- R5: `per_rd` and `duty_rd` return the last written staged value, which can differ from the active one.
- R6: With `center_sel`=0, the counter runs from 0 to P-1 and wraps, giving a period of P ticks. `pwm_out` equals `pol` while the count is below the active duty D, and `~pol` otherwise.
- R7: With `center_sel`=1, the counter visits 0..P-1 upward and then P-1..0 downward, giving a period of 2P ticks in which `pwm_out` equals `pol` for 2D ticks. Reloading happens when the downward count leaves 0.
- R8: If D >= P (this includes P = 0), `pwm_out` stays at `pol`. If D = 0 and P > 0, it stays at `~pol`.
- R9: A `cnt_wr` pulse while running returns the counter to 0 and loads the staged values into the active registers at once.
- R10: The counter advances only on clock edges where `tick` is 1.
- R11: While `ch_en` is 0, `pwm_out` equals `~pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled channel clock enable |
| ch_en | input | 1 | Channel run enable |
| center_sel | input | 1 | 0 = edge aligned, 1 = center aligned |
| pol | input | 1 | Active output level |
| per_wr | input | 1 | Period write strobe |
| duty_wr | input | 1 | Duty write strobe |
| cnt_wr | input | 1 | Counter restart strobe |
| wr_data | input | W | Shared write data |
| per_rd | output | W | Staged period readback |
| duty_rd | output | W | Staged duty readback |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach is a new setting arriving in the middle of a running period. The bench must show that the old active values finish that period and the new ones take over exactly at the wrap. To reach it, the bench starts the channel from a known count of zero and writes period and duty a few ticks in. It then counts active-level cycles across both periods; a premature or missing update gives a different total. The same counting method covers the restart strobe and the reload on turning the channel off, using totals chosen so that every wrong loading point yields a distinct number.

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ch_en,
  input  logic         center_sel,
  input  logic         pol,
  input  logic         per_wr,
  input  logic         duty_wr,
  input  logic         cnt_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] per_rd,
  output logic [W-1:0] duty_rd,
  output logic         pwm_out
);

  logic [W-1:0] per_buf, duty_buf, per_act, duty_act, cnt;
  logic         dir_dn;
  logic         at_top, active;

  assign at_top  = (per_act == '0) || (cnt >= per_act - 1'b1);
  assign active  = (duty_act >= per_act) || (cnt < duty_act);
  assign pwm_out = ch_en ? (active ? pol : ~pol) : ~pol;
  assign per_rd  = per_buf;
  assign duty_rd = duty_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_buf  <= '0;
      duty_buf <= '0;
    end else begin
      if (per_wr)  per_buf  <= wr_data;
      if (duty_wr) duty_buf <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act  <= '0;
      duty_act <= '0;
      cnt      <= '0;
      dir_dn   <= 1'b0;
    end else if (!ch_en) begin
      cnt      <= '0;
      dir_dn   <= 1'b0;
      per_act  <= per_wr  ? wr_data : per_buf;
      duty_act <= duty_wr ? wr_data : duty_buf;
    end else if (cnt_wr) begin
      cnt      <= '0;
      dir_dn   <= 1'b0;
      per_act  <= per_buf;
      duty_act <= duty_buf;
    end else if (tick) begin
      if (!center_sel) begin
        dir_dn <= 1'b0;
        if (at_top) begin
          cnt      <= '0;
          per_act  <= per_buf;
          duty_act <= duty_buf;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (!dir_dn) begin
        if (per_act == '0) begin
          per_act  <= per_buf;
          duty_act <= duty_buf;
        end else if (at_top) begin
          dir_dn <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt == '0) begin
          dir_dn   <= 1'b0;
          per_act  <= per_buf;
          duty_act <= duty_buf;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_PER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && $past(ch_en) && cnt != '0) |-> $stable(per_act)); // R2
  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && $past(ch_en) && cnt != '0) |-> $stable(duty_act)); // R2
  AST_IDLE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en && per_wr) |=> per_act == $past(wr_data)); // R3
  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr |=> per_rd == $past(wr_data)); // R5
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act != '0) |-> cnt < per_act); // R6
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ch_en) && ch_en && !$past(tick) && !$past(cnt_wr)) |-> $stable(cnt)); // R10

endmodule

// File: tb/test_pwm_dbuf_channel.sv
module test_pwm_dbuf_channel;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NV = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, ch_en = 1'b0, center_sel = 1'b0, pol = 1'b1;
  logic per_wr = 1'b0, duty_wr = 1'b0, cnt_wr = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] per_rd, duty_rd;
  logic pwm_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dbuf_channel #(.W(W)) i_pwm_dbuf_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ch_en(ch_en),
    .center_sel(center_sel), .pol(pol), .per_wr(per_wr), .duty_wr(duty_wr),
    .cnt_wr(cnt_wr), .wr_data(wr_data), .per_rd(per_rd), .duty_rd(duty_rd),
    .pwm_out(pwm_out)
  );

  // {center, period, duty, pol, window, expected active-level samples}
  typedef struct packed {
    logic        c;
    logic [7:0]  p;
    logic [7:0]  d;
    logic        pl;
    logic [15:0] n;
    logic [15:0] e;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'd8,   8'd3,   1'b1, 16'd32,   16'd12},   // R6
    '{1'b0, 8'd8,   8'd0,   1'b1, 16'd32,   16'd0},    // R8
    '{1'b0, 8'd8,   8'd8,   1'b1, 16'd32,   16'd32},   // R8
    '{1'b0, 8'd0,   8'd5,   1'b1, 16'd8,    16'd8},    // R8
    '{1'b0, 8'd5,   8'd2,   1'b0, 16'd20,   16'd8},    // R6
    '{1'b1, 8'd4,   8'd1,   1'b1, 16'd32,   16'd8},    // R7
    '{1'b1, 8'd3,   8'd2,   1'b0, 16'd24,   16'd16},   // R7
    '{1'b1, 8'd6,   8'd9,   1'b1, 16'd48,   16'd48},   // R8
    '{1'b0, 8'd255, 8'd254, 1'b1, 16'd1020, 16'd1016}  // R6
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic c, input logic [W-1:0] p, input logic [W-1:0] d, input logic pl);
    @(negedge clk);
    ch_en = 1'b0; tick = 1'b1; per_wr = 1'b1; wr_data = p;
    @(negedge clk);
    per_wr = 1'b0; duty_wr = 1'b1; wr_data = d;
    @(negedge clk);
    duty_wr = 1'b0; center_sel = c; pol = pl;
  endtask

  task automatic clear_strobes();
    per_wr = 1'b0; duty_wr = 1'b0; cnt_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hits;
    repeat (3) @(negedge clk);
    #1;
    check(per_rd == 0 && duty_rd == 0, "R1 readback after reset", per_rd, 0);
    check(pwm_out == ~pol, "R1 idle level after reset", pwm_out, ~pol);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      cfg(VEC[v].c, VEC[v].p, VEC[v].d, VEC[v].pl);
      #1;
      check(per_rd == VEC[v].p, "R3 readback of idle write", per_rd, VEC[v].p);
      check(pwm_out == ~VEC[v].pl, "R11 disabled output", pwm_out, ~VEC[v].pl);
      hits = 0;
      for (int i = 0; i < int'(VEC[v].n); i++) begin
        @(negedge clk);
        ch_en = 1'b1;
        #1;
        if (pwm_out == VEC[v].pl) hits++;
      end
      check(hits == int'(VEC[v].e), "R6/R7/R8 vector active count", hits, VEC[v].e);
    end

    // R2: mid-period update waits for the wrap
    cfg(1'b0, 8'd10, 8'd5, 1'b1);
    hits = 0;
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      clear_strobes();
      ch_en = 1'b1;
      if (i == 3) begin per_wr = 1'b1; wr_data = 8'd4; end
      if (i == 4) begin duty_wr = 1'b1; wr_data = 8'd2; end
      #1;
      if (i == 5) check(per_rd == 8'd4 && duty_rd == 8'd2, "R5 staged readback", per_rd, 4);
      if (pwm_out == pol) hits++;
    end
    clear_strobes();
    check(hits == 9, "R2 old period completes then new applies", hits, 9);

    // R9: counter restart loads staged values
    cfg(1'b0, 8'd10, 8'd5, 1'b1);
    hits = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      clear_strobes();
      ch_en = 1'b1;
      if (i == 1) begin per_wr = 1'b1; wr_data = 8'd4; end
      if (i == 2) begin duty_wr = 1'b1; wr_data = 8'd1; end
      if (i == 3) cnt_wr = 1'b1;
      #1;
      if (pwm_out == pol) hits++;
    end
    clear_strobes();
    check(hits == 6, "R9 restart with immediate load", hits, 6);

    // R4: values staged while running apply after turning off and on
    cfg(1'b0, 8'd10, 8'd5, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      clear_strobes();
      ch_en = 1'b1;
      if (i == 0) begin per_wr = 1'b1; wr_data = 8'd6; end
      if (i == 1) begin duty_wr = 1'b1; wr_data = 8'd3; end
    end
    @(negedge clk);
    clear_strobes();
    ch_en = 1'b0;
    hits = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      ch_en = 1'b1;
      #1;
      if (pwm_out == pol) hits++;
    end
    check(hits == 12, "R4 reload on disable", hits, 12);

    // R10: counter moves only on tick
    cfg(1'b0, 8'd3, 8'd1, 1'b1);
    hits = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      ch_en = 1'b1;
      tick = (i % 2 == 0);
      #1;
      if (pwm_out == pol) hits++;
    end
    tick = 1'b1;
    check(hits == 4, "R10 half-rate tick", hits, 4);

    @(negedge clk);
    ch_en = 1'b0;
    #1;
    check(pwm_out == ~pol, "R11 output after disable", pwm_out, ~pol);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule